// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block is the interrupt controller on the CPU side of a small processor. Sixteen request lines feed two 8-bit pending registers. Two 8-bit mask registers and a two-bit status word sit beside them. The status word holds a global enable and a transfer-server enable. On every clock the block works out which pending request may be serviced. It then raises a registered interrupt-call request, with the index of the winning source and a vector address derived from that index.

The CPU reports three things to the block: an acknowledge when it takes the call, an instruction-boundary strobe each time an instruction completes, and a flag that marks the completed instruction as protected. After a call is taken, no further call may start until the first instruction of the service routine has completed. The same one-instruction hold applies after any protected instruction. Software can write any pending, mask or status register directly.

The save-all instruction pushes the status word and both masks through a save port, then clears them all. The restore-all instruction loads them back through a restore port. An enable-interrupts strobe sets the global enable.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A high bit of `hw_req` sets the matching pending bit on the next clock, whatever its mask bit holds. Pending bit i maps to `pend_o[i]`: register 0 is bits 7..0 and register 1 is bits 15..8.
- R2: When `call_ack` is high while `call_req` is high, the pending bit at `call_idx` is cleared on that clock. If a hardware request for the same bit arrives on the same clock, the bit stays set.
- R3: `pend_wr[k]` overwrites pending register k in full with `pend_wdata`. Such a write beats any hardware set or acknowledge clear on the same clock, so those events are lost.
- R4: A source is a candidate when it is pending, unmasked and the global enable is set. The winner is the candidate with the highest priority. The order, from highest, is 14, 15, 13, 12, …, 0. `call_vec` equals 0x2000 + 2·`call_idx`.
- R5: Source 14 is nonmaskable. It is a candidate whenever it is pending, regardless of its mask bit and of the global enable.
- R6: An accepted acknowledge drops `call_req` on the next clock. `call_req` stays low until an `instr_done` arrives without `instr_prot`.
- R7: An `instr_done` with `instr_prot` high holds `call_req` low until the next `instr_done` that arrives without `instr_prot`.
- R8: `save_word` always shows {pse, gie, mask[15:0]}. `save_all` clears both masks and both status bits. `restore_all` loads them from `restore_word`, with the same layout. When both strobes arrive together, `restore_all` takes precedence.
- R9: `stat_wr` loads {pse, gie} from `stat_wdata` (bit 1 = pse, bit 0 = gie), and `ei` sets gie. `mask_wr[k]` loads mask register k from `mask_wdata`.
- R10: After a synchronous reset, the pending, mask and status registers all read zero and `call_req` is low.
- R11: `call_req`, `call_idx` and `call_vec` are registered. In any cycle they reflect the pending, mask and status values that the outputs show in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 16 | Hardware request pulses, one per source |
| pend_wr | input | 2 | Software write strobe per pending register |
| pend_wdata | input | 8 | Pending write data |
| mask_wr | input | 2 | Software write strobe per mask register |
| mask_wdata | input | 8 | Mask write data |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | 2 | {pse, gie} write data |
| ei | input | 1 | Enable-interrupts strobe (sets gie) |
| save_all | input | 1 | Save-all strobe: clears status and masks |
| restore_all | input | 1 | Restore-all strobe |
| restore_word | input | 18 | {pse, gie, mask} value to restore |
| instr_done | input | 1 | Instruction-boundary strobe |
| instr_prot | input | 1 | Completed instruction was protected |
| call_ack | input | 1 | CPU takes the interrupt call |
| call_req | output | 1 | Interrupt-call request |
| call_idx | output | 4 | Winning source index |
| call_vec | output | 16 | Vector address of the winner |
| pend_o | output | 16 | Pending registers |
| mask_o | output | 16 | Mask registers |
| gie_o | output | 1 | Global interrupt enable |
| pse_o | output | 1 | Transfer-server enable |
| save_word | output | 18 | {pse, gie, mask} for the save-all push |

## Verification
The assertions assume that `call_ack` carries meaning only while `call_req` is high. They also assume that the save, restore, enable and status-write strobes are single-cycle pulses, as a decoder issues them. The stimulus therefore raises `call_ack` only in cycles where the bench's model predicts a call. It also picks at most one register-control operation per cycle. Hardware requests, software pending writes and acknowledges are still allowed to collide on the same clock, because those collisions carry the last-writer and lost-set behaviour.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic pse;
    logic gie;
  } irq_stat_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] ack_clr,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] pend_nxt
);
  // Order of effects: acknowledge clear, then hardware set, then a software
  // write replaces the whole byte (last writer wins).
  always_comb begin
    pend_nxt = (pend_q & ~ack_clr) | hw_set;
    if (wr_en) pend_nxt = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end

  assert_hw_sets_R1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((pend_q & $past(hw_set)) == $past(hw_set)));

  assert_ack_clears_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((pend_q & $past(ack_clr & ~hw_set)) == '0));

  assert_sw_write_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (pend_q == $past(wdata)));
endmodule

// File: rtl/irq_mask_stat.sv
module irq_mask_stat
  import irq_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int NUM_REG = 2,
  localparam int N      = REG_W * NUM_REG
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REG-1:0] mask_wr,
  input  logic [REG_W-1:0]   mask_wdata,
  input  logic               stat_wr,
  input  irq_stat_t          stat_wdata,
  input  logic               ei,
  input  logic               save_all,
  input  logic               restore_all,
  input  logic [N+1:0]       restore_word,
  output logic [N-1:0]       mask_q,
  output logic [N-1:0]       mask_nxt,
  output irq_stat_t          stat_q,
  output irq_stat_t          stat_nxt
);
  always_comb begin
    mask_nxt = mask_q;
    stat_nxt = stat_q;
    for (int r = 0; r < NUM_REG; r++) begin
      if (mask_wr[r]) mask_nxt[r*REG_W +: REG_W] = mask_wdata;
    end
    if (stat_wr) stat_nxt = stat_wdata;
    if (ei)      stat_nxt.gie = 1'b1;
    if (save_all)    {stat_nxt, mask_nxt} = '0;
    if (restore_all) {stat_nxt, mask_nxt} = restore_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      mask_q <= mask_nxt;
      stat_q <= stat_nxt;
    end
  end

  assert_save_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (save_all && !restore_all) |=> (mask_q == '0 && stat_q == '0));

  assert_restore_loads_R8: assert property (@(posedge clk) disable iff (rst)
    restore_all |=> ({stat_q, mask_q} == $past(restore_word)));

  assert_ei_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (ei && !save_all && !restore_all) |=> stat_q.gie);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N       = 16,
  parameter int NMI_IDX = 14,
  localparam int IW     = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx
);
  // Ascending scan: the highest-numbered candidate wins, then the
  // nonmaskable source overrides everything.
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i]) idx = IW'(i);
    end
    if (cand[NMI_IDX]) idx = IW'(NMI_IDX);
    any = |cand;
  end
endmodule

// File: rtl/irq_call_gate.sv
module irq_call_gate #(
  parameter int              IW       = 4,
  parameter int              VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h2000,
  parameter int              VEC_STEP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_nxt,
  input  logic [IW-1:0]    idx_nxt,
  input  logic             instr_done,
  input  logic             instr_prot,
  input  logic             ack_ok,
  output logic             call_req,
  output logic [IW-1:0]    call_idx,
  output logic [VEC_W-1:0] call_vec
);
  localparam logic [VEC_W-1:0] STEP = VEC_W'(VEC_STEP);

  logic blk_q, blk_nxt;

  // Hold window: opened by a taken call or a protected instruction,
  // closed by the next ordinary instruction boundary.
  always_comb begin
    blk_nxt = blk_q;
    if (instr_done) blk_nxt = instr_prot;
    if (ack_ok)     blk_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q    <= 1'b0;
      call_req <= 1'b0;
      call_idx <= '0;
      call_vec <= VEC_BASE;
    end else begin
      blk_q    <= blk_nxt;
      call_req <= any_nxt && !blk_nxt;
      call_idx <= idx_nxt;
      call_vec <= VEC_BASE + VEC_W'(idx_nxt) * STEP;
    end
  end

  assert_ack_holds_R6: assert property (@(posedge clk) disable iff (rst)
    ack_ok |=> !call_req);

  assert_prot_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (instr_done && instr_prot) |=> !call_req);

  assert_hold_until_done_R6: assert property (@(posedge clk) disable iff (rst)
    (!call_req && !instr_done && !$past(any_nxt && !blk_nxt) && $past(blk_nxt)) |=> !call_req);
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pkg::*;
#(
  parameter int               REG_W    = 8,
  parameter int               NUM_REG  = 2,
  parameter int               NMI_IDX  = 14,
  parameter int               VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h2000,
  parameter int               VEC_STEP = 2,
  localparam int              N        = REG_W * NUM_REG,
  localparam int              IW       = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       hw_req,
  input  logic [NUM_REG-1:0] pend_wr,
  input  logic [REG_W-1:0]   pend_wdata,
  input  logic [NUM_REG-1:0] mask_wr,
  input  logic [REG_W-1:0]   mask_wdata,
  input  logic               stat_wr,
  input  logic [1:0]         stat_wdata,
  input  logic               ei,
  input  logic               save_all,
  input  logic               restore_all,
  input  logic [N+1:0]       restore_word,
  input  logic               instr_done,
  input  logic               instr_prot,
  input  logic               call_ack,
  output logic               call_req,
  output logic [IW-1:0]      call_idx,
  output logic [VEC_W-1:0]   call_vec,
  output logic [N-1:0]       pend_o,
  output logic [N-1:0]       mask_o,
  output logic               gie_o,
  output logic               pse_o,
  output logic [N+1:0]       save_word
);
  localparam logic [N-1:0] NMI_HOT = N'(1) << NMI_IDX;

  logic [N-1:0] pend_nxt, mask_nxt, ack_clr, cand_nxt;
  irq_stat_t    stat_q, stat_nxt;
  logic         ack_ok, any_nxt;
  logic [IW-1:0] idx_nxt;

  assign ack_ok  = call_ack && call_req;
  assign ack_clr = ack_ok ? (N'(1) << call_idx) : '0;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_bank
    irq_pend_bank #(.W(REG_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .hw_set  (hw_req[r*REG_W +: REG_W]),
      .ack_clr (ack_clr[r*REG_W +: REG_W]),
      .wr_en   (pend_wr[r]),
      .wdata   (pend_wdata),
      .pend_q  (pend_o[r*REG_W +: REG_W]),
      .pend_nxt(pend_nxt[r*REG_W +: REG_W])
    );
  end

  irq_mask_stat #(.REG_W(REG_W), .NUM_REG(NUM_REG)) u_mask (
    .clk         (clk),
    .rst         (rst),
    .mask_wr     (mask_wr),
    .mask_wdata  (mask_wdata),
    .stat_wr     (stat_wr),
    .stat_wdata  (irq_stat_t'(stat_wdata)),
    .ei          (ei),
    .save_all    (save_all),
    .restore_all (restore_all),
    .restore_word(restore_word),
    .mask_q      (mask_o),
    .mask_nxt    (mask_nxt),
    .stat_q      (stat_q),
    .stat_nxt    (stat_nxt)
  );

  // Candidates from next-state values, so the registered call outputs
  // line up with the registers visible in the same cycle.
  assign cand_nxt = pend_nxt & ((mask_nxt & {N{stat_nxt.gie}}) | NMI_HOT);

  irq_prio_pick #(.N(N), .NMI_IDX(NMI_IDX)) u_pick (
    .cand(cand_nxt),
    .any (any_nxt),
    .idx (idx_nxt)
  );

  irq_call_gate #(.IW(IW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .any_nxt   (any_nxt),
    .idx_nxt   (idx_nxt),
    .instr_done(instr_done),
    .instr_prot(instr_prot),
    .ack_ok    (ack_ok),
    .call_req  (call_req),
    .call_idx  (call_idx),
    .call_vec  (call_vec)
  );

  assign gie_o     = stat_q.gie;
  assign pse_o     = stat_q.pse;
  assign save_word = {stat_q, mask_o};

  assert_winner_pending_R4: assert property (@(posedge clk) disable iff (rst)
    call_req |-> pend_o[call_idx]);

  assert_winner_allowed_R5: assert property (@(posedge clk) disable iff (rst)
    call_req |-> ((call_idx == IW'(NMI_IDX)) || (gie_o && mask_o[call_idx])));
endmodule

// File: tb/irq_pend_ctrl_bench.sv
`timescale 1ns/1ps
module irq_pend_ctrl_bench;
  logic clk = 1'b0;
  logic rst;
  logic [15:0] hw_req;
  logic [1:0]  pend_wr, mask_wr;
  logic [7:0]  pend_wdata, mask_wdata;
  logic        stat_wr, ei, save_all, restore_all, instr_done, instr_prot, call_ack;
  logic [1:0]  stat_wdata;
  logic [17:0] restore_word;
  logic        call_req, gie_o, pse_o;
  logic [3:0]  call_idx;
  logic [15:0] call_vec, pend_o, mask_o;
  logic [17:0] save_word;

  int n_chk = 0, n_fail = 0;

  // model state
  logic [15:0] m_pend, m_mask;
  logic        m_gie, m_pse, m_blk;

  always #2.5 clk = ~clk;

  irq_pend_ctrl u_irq_pend_ctrl (
    .clk(clk), .rst(rst), .hw_req(hw_req), .pend_wr(pend_wr), .pend_wdata(pend_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .ei(ei), .save_all(save_all), .restore_all(restore_all), .restore_word(restore_word),
    .instr_done(instr_done), .instr_prot(instr_prot), .call_ack(call_ack),
    .call_req(call_req), .call_idx(call_idx), .call_vec(call_vec), .pend_o(pend_o),
    .mask_o(mask_o), .gie_o(gie_o), .pse_o(pse_o), .save_word(save_word));

  function automatic logic [15:0] cand_of(logic [15:0] p, logic [15:0] m, logic g);
    return p & ((m & {16{g}}) | 16'h4000);
  endfunction

  function automatic logic [3:0] win_of(logic [15:0] c);
    logic [3:0] w = 4'd0;
    if (c[14]) return 4'd14;
    for (int i = 15; i >= 0; i--) if (c[i]) begin w = 4'(i); break; end
    return w;
  endfunction

  function automatic logic exp_req();
    return !m_blk && (cand_of(m_pend, m_mask, m_gie) != 16'h0);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [3:0] w;
    check(pend_o == m_pend, "R1 R2 R3 pend", 32'(pend_o), 32'(m_pend));
    check(save_word == {m_pse, m_gie, m_mask}, "R8 R9 save_word", 32'(save_word), 32'({m_pse, m_gie, m_mask}));
    check({pse_o, gie_o, mask_o} == {m_pse, m_gie, m_mask}, "R9 mask/status", 32'({pse_o, gie_o, mask_o}), 32'({m_pse, m_gie, m_mask}));
    check(call_req == exp_req(), "R4 R5 R6 R7 R11 call_req", 32'(call_req), 32'(exp_req()));
    if (exp_req() && call_req) begin
      w = win_of(cand_of(m_pend, m_mask, m_gie));
      check(call_idx == w, "R4 call_idx", 32'(call_idx), 32'(w));
      check(call_vec == 16'h2000 + 16'(w) * 16'd2, "R4 call_vec", 32'(call_vec), 32'(16'h2000 + 16'(w) * 16'd2));
    end
  endtask

  task automatic idle();
    hw_req = '0; pend_wr = '0; pend_wdata = '0; mask_wr = '0; mask_wdata = '0;
    stat_wr = 1'b0; stat_wdata = '0; ei = 1'b0; save_all = 1'b0; restore_all = 1'b0;
    restore_word = '0; instr_done = 1'b0; instr_prot = 1'b0; call_ack = 1'b0;
  endtask

  // Apply the driven inputs for one clock, advance the model, check.
  task automatic step();
    logic        ackv;
    logic [15:0] p, m;
    logic        g, s, b;
    ackv = call_ack && exp_req();
    p = m_pend; m = m_mask; g = m_gie; s = m_pse; b = m_blk;
    if (ackv) p[win_of(cand_of(m_pend, m_mask, m_gie))] = 1'b0;
    p = p | hw_req;
    if (pend_wr[0]) p[7:0]  = pend_wdata;
    if (pend_wr[1]) p[15:8] = pend_wdata;
    if (mask_wr[0]) m[7:0]  = mask_wdata;
    if (mask_wr[1]) m[15:8] = mask_wdata;
    if (stat_wr) {s, g} = stat_wdata;
    if (ei) g = 1'b1;
    if (save_all) {s, g, m} = '0;
    if (restore_all) {s, g, m} = restore_word;
    if (instr_done) b = instr_prot;
    if (ackv) b = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_pend = p; m_mask = m; m_gie = g; m_pse = s; m_blk = b;
    check_all();
    idle();
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    rst = 1'b1;
    m_pend = '0; m_mask = '0; m_gie = 1'b0; m_pse = 1'b0; m_blk = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check(pend_o == 16'h0 && mask_o == 16'h0 && !gie_o && !pse_o, "R10 reset regs",
          32'({pse_o, gie_o, mask_o}), 32'h0);
    check(!call_req, "R10 reset call_req", 32'(call_req), 32'h0);

    // R1: masked request still pends, no call
    hw_req = 16'h0008; step();
    check(pend_o[3] && !call_req, "R1 masked pend", 32'(pend_o), 32'h8);

    // R5: nonmaskable with gie=0 and mask=0
    hw_req = 16'h4000; step();
    check(call_req && call_idx == 4'd14, "R5 nmi call", 32'(call_idx), 32'd14);

    // R2 + R6: acknowledge clears and holds until a plain boundary
    call_ack = 1'b1; step();
    check(!pend_o[14] && !call_req, "R2 ack clear", 32'(pend_o), 32'h8);
    hw_req = 16'h4000; step();
    check(!call_req, "R6 hold after ack", 32'(call_req), 32'h0);
    instr_done = 1'b1; step();
    check(call_req, "R6 release", 32'(call_req), 32'h1);

    // R7: protected boundary holds for one more instruction
    instr_done = 1'b1; instr_prot = 1'b1; step();
    check(!call_req, "R7 prot hold", 32'(call_req), 32'h0);
    instr_done = 1'b1; step();
    check(call_req, "R7 prot release", 32'(call_req), 32'h1);

    // R3: software write wins over same-cycle hardware set
    hw_req = 16'h0004; pend_wr = 2'b01; pend_wdata = 8'h00; step();
    check(!pend_o[2], "R3 lost set", 32'(pend_o), 32'h4000);
    pend_wr = 2'b10; pend_wdata = 8'h00; step();

    // R4 + R9: ei and masks; 15 beats 13, nmi beats 15
    ei = 1'b1; step();
    mask_wr = 2'b10; mask_wdata = 8'hFF; step();
    hw_req = 16'hA000; step();
    check(call_idx == 4'd15, "R4 prio 15 over 13", 32'(call_idx), 32'd15);
    hw_req = 16'h4000; step();
    check(call_idx == 4'd14, "R4 nmi over 15", 32'(call_idx), 32'd14);

    // R8: save clears, restore reloads
    save_all = 1'b1; step();
    check(save_word == 18'h0, "R8 save clears", 32'(save_word), 32'h0);
    restore_all = 1'b1; restore_word = 18'h1FF00; step();
    check(save_word == 18'h1FF00, "R8 restore", 32'(save_word), 32'h1FF00);

    // R2: ack and same-bit hardware set keeps bit
    pend_wr = 2'b10; pend_wdata = 8'h40; step();
    if (call_req) begin
      call_ack = 1'b1; hw_req = 16'h4000; step();
      check(pend_o[14], "R2 ack vs set", 32'(pend_o), 32'h4000);
    end

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      int op;
      hw_req = ($urandom % 4 == 0) ? 16'($urandom & $urandom & $urandom) : 16'h0;
      op = $urandom % 16;
      case (op)
        0: begin pend_wr = 2'($urandom % 3 + 1); pend_wdata = 8'($urandom); end
        1, 2: begin mask_wr = 2'($urandom % 3 + 1); mask_wdata = 8'($urandom); end
        3: begin stat_wr = 1'b1; stat_wdata = 2'($urandom); end
        4: ei = 1'b1;
        5: save_all = 1'b1;
        6: begin restore_all = 1'b1; restore_word = 18'($urandom); end
        default: ;
      endcase
      instr_done = ($urandom % 2) == 0;
      instr_prot = instr_done && (($urandom % 4) == 0);
      call_ack   = exp_req() && (($urandom % 2) == 0);
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule